// File: doc/BRIEF.md
# Masked Transaction-ID Event Filter

This block watches the read-address, write-address and read-data channels of an AXI-style memory port. It produces three single-cycle event pulses: matching read transactions, matching write transactions and matching read data beats. Each pulse feeds the event input of one fixed counter in a neighbouring performance counter bank.

Every channel ID is compared with one shared match value under one shared mask. A bit set to 1 in the mask takes part in the comparison. The mask and three per-stream enables are held in the first configuration word. The match value is held in the second configuration word. Both words sit behind a simple word-addressed register port.

The block also watches the counter bank's event-select programming. When counter 2, 3 or 4 is programmed with event code 73, the enable for its stream turns on. When that counter is programmed with any other code, the enable turns off.

Top module: `axi_id_event_filter`

## Requirements
- R1: After a synchronous active-high reset, both configuration words read as zero and all three event outputs are low.
- R2: The configuration word at byte offset 0x00 holds the read-transaction enable in bit 31, the write-transaction enable in bit 30, the read-beat enable in bit 29 and the 18-bit ID mask in bits 17:0. All other bits read as zero.
- R3: The configuration word at byte offset 0x04 holds the 18-bit ID match value in bits 17:0, and its other bits read as zero. Any other offset reads as zero, and a write to any other offset changes neither word.
- R4: An ID matches when (id AND mask) equals (match AND mask). A zero mask therefore matches every ID.
- R5: `ev_rd_txn` goes high for exactly one cycle, in the cycle after each read-address handshake (valid and ready both high) whose ID matches. Back-to-back handshakes give back-to-back pulses.
- R6: `ev_wr_txn` behaves the same way for write-address handshakes.
- R7: `ev_rd_beat` behaves the same way for read-data beats, using the read-data ID.
- R8: A channel with valid high but ready low, or with ready high but valid low, produces no pulse.
- R9: When a stream's enable is 0, its event output stays low, even for matching handshakes.
- R10: An event-select write with counter index 2, 3 or 4 sets the read-transaction, write-transaction or read-beat enable respectively when the code is 73, and clears it for any other code. Other counter indices change nothing. If the same cycle also holds a register write, the event-select value wins for that one enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after `reg_rd` (zero otherwise) |
| evsel_valid | input | 1 | Counter event-select write observed |
| evsel_counter | input | 4 | Counter index of that write |
| evsel_code | input | 8 | Event code of that write |
| ar_valid | input | 1 | Read-address valid |
| ar_ready | input | 1 | Read-address ready |
| ar_id | input | 18 | Read-address ID |
| aw_valid | input | 1 | Write-address valid |
| aw_ready | input | 1 | Write-address ready |
| aw_id | input | 18 | Write-address ID |
| r_valid | input | 1 | Read-data valid |
| r_ready | input | 1 | Read-data ready |
| r_id | input | 18 | Read-data ID |
| ev_rd_txn | output | 1 | Matching read-transaction pulse |
| ev_wr_txn | output | 1 | Matching write-transaction pulse |
| ev_rd_beat | output | 1 | Matching read-beat pulse |

## Verification
A corrupted mask, match value or enable shows up at the ports in two places. It shows up on the next configuration read-back. It also shows up as a missing or extra pulse one cycle after the first handshake whose ID separates the right comparison from the wrong one. The vector table therefore pairs IDs that differ from the match value only in masked-out bits with IDs that differ only in compared bits. A comparator or pulse register that holds its state too long appears as a second pulse after a single handshake. The enable bits driven by event-select snooping are checked by reading back the first configuration word right after each select write.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam int unsigned CFG_CTRL_OFF = 0;
  localparam int unsigned CFG_ID_OFF   = 4;
  localparam int unsigned EN_RD_BIT    = 31;
  localparam int unsigned EN_WR_BIT    = 30;
  localparam int unsigned EN_BEAT_BIT  = 29;
  localparam int unsigned FILT_CODE    = 73;
  localparam int unsigned CNT_RD_TXN   = 2;
  localparam int unsigned CNT_WR_TXN   = 3;
  localparam int unsigned CNT_RD_BEAT  = 4;
  localparam int unsigned N_STREAMS    = 3;
  typedef enum logic [1:0] {
    STR_RD_TXN  = 2'd0,
    STR_WR_TXN  = 2'd1,
    STR_RD_BEAT = 2'd2
  } stream_e;
endpackage

// File: rtl/axf_cfg_regs.sv
module axf_cfg_regs
  import axf_pkg::*;
#(
  parameter int unsigned ID_W   = 18,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evsel_valid,
  input  logic [CNT_W-1:0]  evsel_counter,
  input  logic [EVT_W-1:0]  evsel_code,
  output logic [N_STREAMS-1:0] enables,
  output logic [ID_W-1:0]   id_mask,
  output logic [ID_W-1:0]   id_match
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CFG_CTRL_OFF);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(CFG_ID_OFF);
  localparam logic [EVT_W-1:0]  CODE   = EVT_W'(FILT_CODE);

  logic [DATA_W-1:0] ctrl_view, id_view, rd_mux;
  logic              sel_code_hit;

  assign sel_code_hit = (evsel_code == CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      enables  <= '0;
      id_mask  <= '0;
      id_match <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        id_mask             <= reg_wdata[ID_W-1:0];
        enables[STR_RD_TXN]  <= reg_wdata[EN_RD_BIT];
        enables[STR_WR_TXN]  <= reg_wdata[EN_WR_BIT];
        enables[STR_RD_BEAT] <= reg_wdata[EN_BEAT_BIT];
      end
      if (reg_wr && reg_addr == A_ID)
        id_match <= reg_wdata[ID_W-1:0];
      // event-select snooping comes last so it wins over a same-cycle write (R10)
      if (evsel_valid) begin
        if (evsel_counter == CNT_W'(CNT_RD_TXN))  enables[STR_RD_TXN]  <= sel_code_hit;
        if (evsel_counter == CNT_W'(CNT_WR_TXN))  enables[STR_WR_TXN]  <= sel_code_hit;
        if (evsel_counter == CNT_W'(CNT_RD_BEAT)) enables[STR_RD_BEAT] <= sel_code_hit;
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[ID_W-1:0]   = id_mask;
    ctrl_view[EN_RD_BIT]   = enables[STR_RD_TXN];
    ctrl_view[EN_WR_BIT]   = enables[STR_WR_TXN];
    ctrl_view[EN_BEAT_BIT] = enables[STR_RD_BEAT];
    id_view = '0;
    id_view[ID_W-1:0] = id_match;
    case (reg_addr)
      A_CTRL:  rd_mux = ctrl_view;
      A_ID:    rd_mux = id_view;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_rd ? rd_mux : '0;
  end

  // R3: a write to the ID word lands in the match value
  assert_id_write_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_ID) |=> (id_match == $past(reg_wdata[ID_W-1:0])));
  // R3: undecoded writes leave mask and match untouched
  assert_stray_write_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr != A_ID && reg_addr != A_CTRL) |=> ($stable(id_mask) && $stable(id_match)));
  // R10: selecting the filter code turns the read-transaction stream on
  assert_evsel_set_R10: assert property (@(posedge clk) disable iff (rst)
    (evsel_valid && evsel_counter == CNT_W'(CNT_RD_TXN) && sel_code_hit) |=> enables[STR_RD_TXN]);
  // R10: another code on the write-transaction counter turns it off
  assert_evsel_clr_R10: assert property (@(posedge clk) disable iff (rst)
    (evsel_valid && evsel_counter == CNT_W'(CNT_WR_TXN) && !sel_code_hit) |=> !enables[STR_WR_TXN]);
  // R1: read data is quiet when no read was requested
  assert_rdata_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));
endmodule

// File: rtl/axf_id_match.sv
module axf_id_match #(
  parameter int unsigned ID_W = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic [ID_W-1:0] id_mask,
  input  logic [ID_W-1:0] id_match,
  input  logic            ch_valid,
  input  logic            ch_ready,
  input  logic [ID_W-1:0] ch_id,
  output logic            ev_pulse
);
  logic id_hit;
  logic fire;

  assign id_hit = ((ch_id ^ id_match) & id_mask) == '0;
  assign fire   = ch_valid && ch_ready;

  always_ff @(posedge clk) begin
    if (rst) ev_pulse <= 1'b0;
    else     ev_pulse <= enable && fire && id_hit;
  end

  // R9: a disabled stream never pulses
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !ev_pulse);
  // R8: no handshake, no pulse
  assert_no_handshake_R8: assert property (@(posedge clk) disable iff (rst)
    !(ch_valid && ch_ready) |=> !ev_pulse);
  // R5: every pulse is preceded by a handshake one cycle earlier
  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (rst)
    ev_pulse |-> $past(ch_valid && ch_ready));
endmodule

// File: rtl/axi_id_event_filter.sv
module axi_id_event_filter
  import axf_pkg::*;
#(
  parameter int unsigned ID_W   = 18,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evsel_valid,
  input  logic [CNT_W-1:0]  evsel_counter,
  input  logic [EVT_W-1:0]  evsel_code,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              ev_rd_txn,
  output logic              ev_wr_txn,
  output logic              ev_rd_beat
);
  logic [N_STREAMS-1:0]           enables;
  logic [ID_W-1:0]                id_mask, id_match;
  logic [N_STREAMS-1:0]           s_valid, s_ready, s_pulse;
  logic [N_STREAMS-1:0][ID_W-1:0] s_id;

  axf_cfg_regs #(
    .ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .EVT_W(EVT_W)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evsel_valid(evsel_valid), .evsel_counter(evsel_counter), .evsel_code(evsel_code),
    .enables(enables), .id_mask(id_mask), .id_match(id_match)
  );

  assign s_valid[STR_RD_TXN]  = ar_valid;
  assign s_ready[STR_RD_TXN]  = ar_ready;
  assign s_id[STR_RD_TXN]     = ar_id;
  assign s_valid[STR_WR_TXN]  = aw_valid;
  assign s_ready[STR_WR_TXN]  = aw_ready;
  assign s_id[STR_WR_TXN]     = aw_id;
  assign s_valid[STR_RD_BEAT] = r_valid;
  assign s_ready[STR_RD_BEAT] = r_ready;
  assign s_id[STR_RD_BEAT]    = r_id;

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_stream
    axf_id_match #(.ID_W(ID_W)) u_match (
      .clk(clk), .rst(rst),
      .enable(enables[g]), .id_mask(id_mask), .id_match(id_match),
      .ch_valid(s_valid[g]), .ch_ready(s_ready[g]), .ch_id(s_id[g]),
      .ev_pulse(s_pulse[g])
    );
  end

  assign ev_rd_txn  = s_pulse[STR_RD_TXN];
  assign ev_wr_txn  = s_pulse[STR_WR_TXN];
  assign ev_rd_beat = s_pulse[STR_RD_BEAT];

  // R1: all event outputs are low in the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ev_rd_txn && !ev_wr_txn && !ev_rd_beat));
endmodule

// File: tb/test_axi_id_event_filter.sv
module test_axi_id_event_filter;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        evsel_valid;
  logic [3:0]  evsel_counter;
  logic [7:0]  evsel_code;
  logic        ar_valid, ar_ready, aw_valid, aw_ready, r_valid, r_ready;
  logic [17:0] ar_id, aw_id, r_id;
  logic        ev_rd_txn, ev_wr_txn, ev_rd_beat;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  axi_id_event_filter i_axi_id_event_filter (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evsel_valid(evsel_valid), .evsel_counter(evsel_counter), .evsel_code(evsel_code),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
    .ev_rd_txn(ev_rd_txn), .ev_wr_txn(ev_wr_txn), .ev_rd_beat(ev_rd_beat)
  );

  // {channel(0=ar,1=aw,2=r), mask, match, id, valid, ready, expected}
  localparam int NV = 9;
  localparam logic [58:0] VEC [0:NV-1] = '{
    {2'd0, 18'h3FFFF, 18'h00123, 18'h00123, 3'b111},
    {2'd0, 18'h3FFFF, 18'h00123, 18'h00124, 3'b110},
    {2'd1, 18'h000FF, 18'h3FF55, 18'h00055, 3'b111},
    {2'd1, 18'h000FF, 18'h00055, 18'h00056, 3'b110},
    {2'd2, 18'h00000, 18'h12345, 18'h3ABCD, 3'b111},
    {2'd2, 18'h20000, 18'h20000, 18'h1FFFF, 3'b110},
    {2'd0, 18'h3FFFF, 18'h00001, 18'h00001, 3'b100},
    {2'd2, 18'h3FFFF, 18'h00007, 18'h00007, 3'b010},
    {2'd1, 18'h3FFFF, 18'h2AAAA, 18'h2AAAA, 3'b111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic evsel(input logic [3:0] c, input logic [7:0] code);
    @(negedge clk);
    evsel_valid = 1'b1; evsel_counter = c; evsel_code = code;
    @(negedge clk);
    evsel_valid = 1'b0;
  endtask

  task automatic drive(input logic [1:0] ch, input logic v, input logic rd, input logic [17:0] id);
    ar_valid = 1'b0; ar_ready = 1'b0; aw_valid = 1'b0; aw_ready = 1'b0;
    r_valid = 1'b0; r_ready = 1'b0;
    case (ch)
      2'd0: begin ar_valid = v; ar_ready = rd; ar_id = id; end
      2'd1: begin aw_valid = v; aw_ready = rd; aw_id = id; end
      default: begin r_valid = v; r_ready = rd; r_id = id; end
    endcase
  endtask

  function automatic logic [2:0] outs();
    return {ev_rd_beat, ev_wr_txn, ev_rd_txn};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    evsel_valid = 1'b0; evsel_counter = '0; evsel_code = '0;
    ar_id = '0; aw_id = '0; r_id = '0;
    drive(2'd0, 1'b0, 1'b0, 18'h0);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 outputs", {29'd0, outs()}, 32'd0);
    reg_read(8'h00, rv); chk("R1 ctrl word", rv, 32'h0);
    reg_read(8'h04, rv); chk("R1 id word", rv, 32'h0);

    // R2: control word fields, unused bits zero
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, rv); chk("R2 ctrl readback", rv, 32'hE003_FFFF);
    // R3: id word and undecoded offset
    reg_write(8'h04, 32'hFFFF_FFFF);
    reg_read(8'h04, rv); chk("R3 id readback", rv, 32'h0003_FFFF);
    reg_write(8'h08, 32'h1234_5678);
    reg_read(8'h08, rv); chk("R3 undecoded read", rv, 32'h0);
    reg_read(8'h04, rv); chk("R3 stray write ignored", rv, 32'h0003_FFFF);
    reg_read(8'h00, rv); chk("R3 stray write ctrl", rv, 32'hE003_FFFF);

    // R4 R5 R6 R7 R8: vector table, one handshake per entry
    for (int i = 0; i < NV; i++) begin
      logic [58:0] v;
      logic [2:0]  exp;
      v = VEC[i];
      reg_write(8'h00, 32'hE000_0000 | {14'd0, v[56:39]});
      reg_write(8'h04, {14'd0, v[38:21]});
      @(negedge clk);
      drive(v[58:57], v[2], v[1], v[20:3]);
      @(negedge clk);
      drive(2'd0, 1'b0, 1'b0, 18'h0);
      exp = '0;
      exp[v[58:57]] = v[0];
      chk($sformatf("R4/R5/R6/R7/R8 vector %0d", i), {29'd0, outs()}, {29'd0, exp});
    end

    // R5: back-to-back handshakes give back-to-back single pulses
    reg_write(8'h00, 32'hE000_0000);
    @(negedge clk);
    drive(2'd0, 1'b1, 1'b1, 18'h00AAA);
    @(negedge clk);
    chk("R5 first pulse", {31'd0, ev_rd_txn}, 32'd1);
    @(negedge clk);
    chk("R5 second pulse", {31'd0, ev_rd_txn}, 32'd1);
    drive(2'd0, 1'b0, 1'b0, 18'h0);
    @(negedge clk);
    chk("R5 pulse ends", {31'd0, ev_rd_txn}, 32'd0);

    // R9: disabled streams stay low while the enabled one still fires
    reg_write(8'h00, 32'h8000_0000);
    @(negedge clk); drive(2'd1, 1'b1, 1'b1, 18'h0);
    @(negedge clk); drive(2'd0, 1'b0, 1'b0, 18'h0);
    chk("R9 write stream disabled", {29'd0, outs()}, 32'd0);
    @(negedge clk); drive(2'd2, 1'b1, 1'b1, 18'h0);
    @(negedge clk); drive(2'd0, 1'b0, 1'b0, 18'h0);
    chk("R9 beat stream disabled", {29'd0, outs()}, 32'd0);
    @(negedge clk); drive(2'd0, 1'b1, 1'b1, 18'h0);
    @(negedge clk); drive(2'd0, 1'b0, 1'b0, 18'h0);
    chk("R9 read stream enabled", {29'd0, outs()}, 32'd1);

    // R10: event-select snooping
    reg_write(8'h00, 32'h0000_0000);
    evsel(4'd3, 8'd73);
    reg_read(8'h00, rv); chk("R10 set write enable", rv, 32'h4000_0000);
    evsel(4'd4, 8'd73);
    reg_read(8'h00, rv); chk("R10 set beat enable", rv, 32'h6000_0000);
    evsel(4'd3, 8'd5);
    reg_read(8'h00, rv); chk("R10 clear write enable", rv, 32'h2000_0000);
    evsel(4'd7, 8'd73);
    reg_read(8'h00, rv); chk("R10 other counter ignored", rv, 32'h2000_0000);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0000_0011;
    evsel_valid = 1'b1; evsel_counter = 4'd2; evsel_code = 8'd73;
    @(negedge clk);
    reg_wr = 1'b0; evsel_valid = 1'b0;
    reg_read(8'h00, rv); chk("R10 select wins over write", rv, 32'h8000_0011);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule